// File: doc/BRIEF.md
# Multi-Slot TDM Audio Serial Receiver

This block receives a time-division-multiplexed audio stream as a frame slave. The bit clock, frame sync and serial data arrive from an external transmitter and are oversampled by a faster system clock. The system clock must run at least four times faster than the bit clock. The block finds the frame start from the frame sync and counts bits and slots from that point. Each slot's sample is collected MSB first. When a slot completes, the block presents the sample as a sign-extended parallel word, together with the slot number and a single-cycle valid strobe.

Every framing setting is a static configuration input and must match the transmitter. The settings are the slots per frame, bits per slot, sample width inside the slot, sync polarity, the bit-clock edge used for sampling, the optional one-bit delay after the frame start, and left or right placement of the sample. Change the configuration only while reset is held. If a sync edge arrives earlier or later than the configured frame length, the block flags a framing error and restarts counting from slot 0.

Top module: `tdm_slot_rx`

## Requirements
- R1: `cfg_slots_sel` selects the slots per frame: 0→2, 1→4, 2→8, 3→12, 4→16, 5→32. `rx_slot` runs 0 up to the count minus 1 in each frame. Bits that arrive after the last slot and before the next frame start produce no output.
- R2: A frame starts at the first sampled bit where the sync is at its active level after being inactive. The active level is high when `cfg_sync_low`=0 and low when it is 1. A one-bit pulse and a sync held active for half the frame give the same words.
- R3: Data and sync are sampled on the rising bit-clock edge when `cfg_sample_fall`=0 and on the falling edge when it is 1.
- R4: With `cfg_delay1`=0, the bit sampled together with the sync edge is bit 0 of slot 0. With `cfg_delay1`=1, bit 0 of slot 0 is the next sampled bit.
- R5: A slot holds `cfg_slot_bits` bits. The sample is `cfg_sample_bits` bits long and sent MSB first. It occupies the first bits of the slot when `cfg_right_just`=0 and the last bits of the slot when it is 1.
- R6: Each completed slot gives one single-cycle `rx_valid` pulse. At that pulse, `rx_data` holds the sample sign-extended from bit `cfg_sample_bits`-1, and slot bits outside the sample window have no effect on it.
- R7: After the first frame start, a sync edge that comes after a bit count other than slots × slot bits raises `frame_err` for one cycle. The new frame then starts at slot 0.
- R8: After reset, `rx_valid` and `frame_err` are low, and no word is produced before the first frame start.
- R9: If the receiver uses no delay while the transmitter applies a one-bit delay, each word is shifted right by one bit. The MSB of the word is the bit that preceded the slot on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4× the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slots_sel | input | 3 | Slots-per-frame code (R1) |
| cfg_slot_bits | input | 6 | Bits per slot, 2 to 32 |
| cfg_sample_bits | input | 6 | Sample width, 1 to cfg_slot_bits |
| cfg_sync_low | input | 1 | Frame sync active low when 1 |
| cfg_sample_fall | input | 1 | Sample on falling bit-clock edge when 1 |
| cfg_delay1 | input | 1 | First data bit one bit after the sync edge when 1 |
| cfg_right_just | input | 1 | Sample at the end of the slot when 1 |
| bclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame sync |
| sdata_in | input | 1 | External serial data |
| rx_valid | output | 1 | One-cycle strobe per completed slot |
| rx_slot | output | 5 | Slot number of the word |
| rx_data | output | OUT_W | Sign-extended sample |
| frame_err | output | 1 | One-cycle framing error pulse |

## Verification
The bench sweeps every slot count and combines each with a sync polarity, sampling edge, delay setting, sample placement, pulse or half-frame sync, and narrowed sample widths. A wrong sampling edge or delay would shift every word by one bit. A wrong window would let the padding bits, which are driven to 1, leak into the word or corrupt its sign. A separate run sends a short frame and then a frame with extra trailing bits. A tracker that ignored the bit count would miss the error pulse or keep numbering slots from the old position, and a tracker that did not stop after the last slot would emit extra words. A deliberate delay mismatch checks that the one-bit shift shows up exactly as predicted, with no framing error.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  // width of slot-bit and sample-bit counts; slots are at most 2**(CW-1) bits
  localparam int CW = 6;
  // frame bit counter width, holds slots*slot_bits
  localparam int FW = 2 * CW;

  typedef enum logic [2:0] {
    SLOTS_2  = 3'd0,
    SLOTS_4  = 3'd1,
    SLOTS_8  = 3'd2,
    SLOTS_12 = 3'd3,
    SLOTS_16 = 3'd4,
    SLOTS_32 = 3'd5
  } slots_e;

  typedef struct packed {
    logic [2:0]    slots_sel;
    logic [CW-1:0] slot_bits;
    logic [CW-1:0] sample_bits;
    logic          sync_low;
    logic          samp_fall;
    logic          delay1;
    logic          rjust;
  } rx_cfg_t;

  function automatic logic [CW-1:0] slots_of(input logic [2:0] sel);
    case (sel)
      SLOTS_4:  slots_of = CW'(4);
      SLOTS_8:  slots_of = CW'(8);
      SLOTS_12: slots_of = CW'(12);
      SLOTS_16: slots_of = CW'(16);
      SLOTS_32: slots_of = CW'(32);
      default:  slots_of = CW'(2);
    endcase
  endfunction
endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_fall,
  input  logic bclk,
  input  logic fsync,
  input  logic sdata,
  output logic fs_s,
  output logic sd_s,
  output logic samp_en
);
  localparam int LINES = 3;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] tap;
  logic             bclk_d_q;

  assign raw = {bclk, fsync, sdata};

  if (STAGES == 1) begin : g_single
    logic [LINES-1:0] stg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= raw;
    end
    assign tap = stg_q;
  end else begin : g_chain
    logic [STAGES-1:0][LINES-1:0] stg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], raw};
    end
    assign tap = stg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d_q <= 1'b0;
    else        bclk_d_q <= tap[2];
  end

  assign fs_s    = tap[1];
  assign sd_s    = tap[0];
  assign samp_en = samp_fall ? (bclk_d_q & ~tap[2]) : (~bclk_d_q & tap[2]);

  AST_EDGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |=> !samp_en); // R3
endmodule

// File: rtl/tdm_rx_frame.sv
module tdm_rx_frame
  import tdm_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_en,
  input  logic          fs_s,
  input  rx_cfg_t       cfg,
  output logic          bit_ev,
  output logic [CW-1:0] bit_idx,
  output logic [CW-1:0] slot_idx,
  output logic          frame_err
);
  logic          fs_prev_q, fs_prev_d;
  logic          dly_q, dly_d;
  logic          lock_q, lock_d;
  logic          err_q, err_d;
  logic [CW-1:0] bit_q, bit_d, slot_q, slot_d;
  logic [FW-1:0] frm_q, frm_d;
  logic [CW-1:0] nslots, cur_bit, cur_slot;
  logic [FW-1:0] frame_len;
  logic          fs_act, lead, start_now, active;

  always_comb begin
    nslots    = slots_of(cfg.slots_sel);
    frame_len = FW'(nslots) * FW'(cfg.slot_bits);
    fs_act    = fs_s ^ cfg.sync_low;
    lead      = fs_act & ~fs_prev_q;
    start_now = cfg.delay1 ? dly_q : lead;
    cur_bit   = start_now ? '0 : bit_q;
    cur_slot  = start_now ? '0 : slot_q;
    active    = (lock_q | start_now) & (cur_slot < nslots);

    fs_prev_d = fs_prev_q;
    dly_d     = dly_q;
    lock_d    = lock_q;
    err_d     = 1'b0;
    bit_d     = bit_q;
    slot_d    = slot_q;
    frm_d     = frm_q;
    if (samp_en) begin
      fs_prev_d = fs_act;
      dly_d     = lead;
      if (start_now) begin
        lock_d = 1'b1;
        err_d  = lock_q & (frm_q != frame_len);
        frm_d  = FW'(1);
      end else if (frm_q != '1) begin
        frm_d = frm_q + 1'b1;
      end
      if (active) begin
        if (cur_bit == cfg.slot_bits - 1'b1) begin
          bit_d  = '0;
          slot_d = cur_slot + 1'b1;
        end else begin
          bit_d  = cur_bit + 1'b1;
          slot_d = cur_slot;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b0;
      dly_q     <= 1'b0;
      lock_q    <= 1'b0;
      err_q     <= 1'b0;
      bit_q     <= '0;
      slot_q    <= '0;
      frm_q     <= '0;
    end else begin
      err_q <= err_d;
      if (samp_en) begin
        fs_prev_q <= fs_prev_d;
        dly_q     <= dly_d;
        lock_q    <= lock_d;
        bit_q     <= bit_d;
        slot_q    <= slot_d;
        frm_q     <= frm_d;
      end
    end
  end

  assign bit_ev    = samp_en & active;
  assign bit_idx   = cur_bit;
  assign slot_idx  = cur_slot;
  assign frame_err = err_q;

  AST_ERR_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(lock_q)); // R7
  AST_NO_BITS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !dly_q && !lead) |-> !bit_ev); // R8
endmodule

// File: rtl/tdm_rx_slot.sv
module tdm_rx_slot
  import tdm_rx_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_ev,
  input  logic [CW-1:0]    bit_idx,
  input  logic [CW-1:0]    slot_idx,
  input  logic             sd_s,
  input  logic [CW-1:0]    slot_bits,
  input  logic [CW-1:0]    sample_bits,
  input  logic             rjust,
  output logic             valid,
  output logic [4:0]       slot,
  output logic [OUT_W-1:0] data
);
  // shift register spans the longest slot; OUT_W must be at least SH_W
  localparam int SH_W = 1 << (CW - 1);
  localparam int IW   = $clog2(SH_W);

  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CW-1:0]    win_lo;
  logic             in_win, last;
  logic             sign;
  logic [IW-1:0]    sign_idx;
  logic [OUT_W-1:0] ext;
  logic             valid_q;
  logic [4:0]       slot_q;
  logic [OUT_W-1:0] data_q;

  always_comb begin
    win_lo = rjust ? (slot_bits - sample_bits) : '0;
    in_win = (bit_idx >= win_lo) && (bit_idx < win_lo + sample_bits);
    sh_d   = sh_q;
    if (bit_ev && in_win) begin
      if (bit_idx == win_lo) sh_d = SH_W'(sd_s);
      else                   sh_d = {sh_q[SH_W-2:0], sd_s};
    end
    last     = bit_ev && (bit_idx == slot_bits - 1'b1);
    sign_idx = IW'(sample_bits - 1'b1);
    sign     = sh_d[sign_idx];
    ext      = {OUT_W{sign}};
    for (int i = 0; i < SH_W; i++) begin
      if (i < int'(sample_bits)) ext[i] = sh_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
      slot_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= last;
      if (bit_ev) sh_q <= sh_d;
      if (last) begin
        slot_q <= slot_idx[4:0];
        data_q <= ext;
      end
    end
  end

  assign valid = valid_q;
  assign slot  = slot_q;
  assign data  = data_q;
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_rx_pkg::*;
#(
  parameter int OUT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_slots_sel,
  input  logic [5:0]       cfg_slot_bits,
  input  logic [5:0]       cfg_sample_bits,
  input  logic             cfg_sync_low,
  input  logic             cfg_sample_fall,
  input  logic             cfg_delay1,
  input  logic             cfg_right_just,
  input  logic             bclk_in,
  input  logic             fsync_in,
  input  logic             sdata_in,
  output logic             rx_valid,
  output logic [4:0]       rx_slot,
  output logic [OUT_W-1:0] rx_data,
  output logic             frame_err
);
  logic [1:0]    rst_q;
  logic          rst_ni;
  rx_cfg_t       cfg;
  logic          fs_s, sd_s, samp_en;
  logic          bit_ev;
  logic [CW-1:0] bit_idx, slot_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  always_comb begin
    cfg.slots_sel   = cfg_slots_sel;
    cfg.slot_bits   = CW'(cfg_slot_bits);
    cfg.sample_bits = CW'(cfg_sample_bits);
    cfg.sync_low    = cfg_sync_low;
    cfg.samp_fall   = cfg_sample_fall;
    cfg.delay1      = cfg_delay1;
    cfg.rjust       = cfg_right_just;
  end

  tdm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ni),
    .samp_fall (cfg.samp_fall),
    .bclk      (bclk_in),
    .fsync     (fsync_in),
    .sdata     (sdata_in),
    .fs_s      (fs_s),
    .sd_s      (sd_s),
    .samp_en   (samp_en)
  );

  tdm_rx_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_ni),
    .samp_en   (samp_en),
    .fs_s      (fs_s),
    .cfg       (cfg),
    .bit_ev    (bit_ev),
    .bit_idx   (bit_idx),
    .slot_idx  (slot_idx),
    .frame_err (frame_err)
  );

  tdm_rx_slot #(.OUT_W(OUT_W)) u_slot (
    .clk         (clk),
    .rst_n       (rst_ni),
    .bit_ev      (bit_ev),
    .bit_idx     (bit_idx),
    .slot_idx    (slot_idx),
    .sd_s        (sd_s),
    .slot_bits   (cfg.slot_bits),
    .sample_bits (cfg.sample_bits),
    .rjust       (cfg.rjust),
    .valid       (rx_valid),
    .slot        (rx_slot),
    .data        (rx_data)
  );

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_valid |=> !rx_valid); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_valid |-> ({1'b0, rx_slot} < slots_of(cfg_slots_sel))); // R1
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    frame_err |=> !frame_err); // R7
endmodule

// File: tb/tdm_slot_rx_test.sv
module tdm_slot_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_slots_sel = 3'd0;
  logic [5:0]  cfg_slot_bits = 6'd8;
  logic [5:0]  cfg_sample_bits = 6'd8;
  logic        cfg_sync_low = 1'b0;
  logic        cfg_sample_fall = 1'b0;
  logic        cfg_delay1 = 1'b0;
  logic        cfg_right_just = 1'b0;
  logic        bclk_in = 1'b0;
  logic        fsync_in = 1'b0;
  logic        sdata_in = 1'b0;
  logic        rx_valid;
  logic [4:0]  rx_slot;
  logic [31:0] rx_data;
  logic        frame_err;

  always #4 clk = ~clk;

  tdm_slot_rx uut (.*);

  int total = 0, bad = 0;
  int gn = 0, errs = 0;
  logic [31:0] got_d [128];
  int          got_s [128];
  logic [31:0] exp_d [128];
  int          exp_s [128];
  int          en = 0;
  int W, S, N, L, cidx;
  bit rj, tx_dly, mode50;

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid && gn < 128) begin
      got_d[gn] = rx_data;
      got_s[gn] = int'(rx_slot);
      gn++;
    end
    if (rst_n && frame_err) errs++;
  end

  function automatic int nslots(input int sel);
    case (sel)
      1: return 4; 2: return 8; 3: return 12; 4: return 16; 5: return 32;
      default: return 2;
    endcase
  endfunction

  function automatic int val(input int f, input int s);
    return (s * 73 + f * 29 + cidx * 13 + 5) & ((1 << S) - 1);
  endfunction

  function automatic logic [31:0] sx(input int v, input int w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  function automatic bit tx_bit(input int f, input int s, input int b);
    int lo = rj ? W - S : 0;
    int v  = val(f, s);
    if (b >= lo && b < lo + S) return v[S - 1 - (b - lo)];
    return 1'b1; // padding driven high
  endfunction

  function automatic bit fs_at(input int p);
    int fp = tx_dly ? (p + 1) % L : p;
    if (mode50) return fp < L / 2;
    return fp == 0;
  endfunction

  task automatic put_bit(input bit d, input bit fs_active);
    @(posedge clk); #1;
    bclk_in  = cfg_sample_fall;
    fsync_in = fs_active ^ cfg_sync_low;
    sdata_in = d;
    repeat (4) @(posedge clk);
    #1 bclk_in = ~cfg_sample_fall;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_frame(input int f, input int nbits);
    for (int p = 0; p < nbits; p++) put_bit(tx_bit(f, p / W, p % W), fs_at(p));
  endtask

  task automatic start_run(input int sel, input int wb, input int sb, input bit low,
                           input bit fall, input bit rxd, input bit rjus, input bit txd,
                           input bit m50, input int id);
    rst_n = 1'b0;
    cfg_slots_sel = 3'(sel); cfg_slot_bits = 6'(wb); cfg_sample_bits = 6'(sb);
    cfg_sync_low = low; cfg_sample_fall = fall; cfg_delay1 = rxd; cfg_right_just = rjus;
    N = nslots(sel); W = wb; S = sb; L = N * W; rj = rjus; tx_dly = txd; mode50 = m50; cidx = id;
    bclk_in = fall; fsync_in = low; sdata_in = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    gn = 0; errs = 0; en = 0;
    for (int k = 0; k < 3; k++) put_bit(1'b1, 1'b0);
    chk(gn == 0, "R8 no words before first frame start", gn, 0);
    if (txd) put_bit(1'b0, 1'b1);
  endtask

  task automatic finish_run(input string tag, input int exp_errs);
    repeat (6) @(posedge clk);
    chk(gn == en, {tag, " R1 word count"}, gn, en);
    for (int i = 0; i < en && i < gn; i++) begin
      chk(got_s[i] == exp_s[i], {tag, " R1 slot index"}, got_s[i], exp_s[i]);
      chk(got_d[i] == exp_d[i], {tag, " R5 R6 word"}, got_d[i], exp_d[i]);
    end
    chk(errs == exp_errs, {tag, " R7 framing errors"}, errs, exp_errs);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk(rx_valid == 1'b0, "R8 reset valid", rx_valid, 0);
    chk(frame_err == 1'b0, "R8 reset frame_err", frame_err, 0);

    // sweep: every slot count, mixing polarity, edge, delay, placement, sync shape, width
    for (int c = 0; c < 12; c++) begin
      int sel = c % 6;
      int wb  = 8 + 4 * (c % 2);
      int sb  = wb - 2 * ((c / 2) % 3);
      bit low = (c / 3) % 2;
      bit fal = (c / 2) % 2;
      bit dly = (c / 4) % 2;
      bit rjs = ((c + 1) / 3) % 2;
      bit m50 = (c / 5) % 2;
      start_run(sel, wb, sb, low, fal, dly, rjs, dly, m50, c);
      for (int f = 0; f < 2; f++)
        for (int s = 0; s < N; s++) begin
          exp_d[en] = sx(val(f, s), S); exp_s[en] = s; en++;
        end
      for (int f = 0; f < 2; f++) send_frame(f, L);
      finish_run("R2 R3 R4 sweep", 0);
    end

    // framing errors: short frame, then long frame (R7), no words past last slot (R1)
    start_run(0, 8, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20);
    send_frame(0, L);
    send_frame(1, 5);
    send_frame(2, L);
    send_frame(3, L);
    for (int k = 0; k < 3; k++) put_bit(1'b1, 1'b0);
    send_frame(4, L);
    for (int f = 0; f < 5; f++)
      if (f != 1)
        for (int s = 0; s < N; s++) begin
          exp_d[en] = sx(val(f, s), S); exp_s[en] = s; en++;
        end
    finish_run("R7 restart", 2);

    // delay mismatch: transmitter delays, receiver does not (R9)
    start_run(1, 8, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 21);
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < N; s++) begin
        int prev;
        int v;
        if (s > 0)      prev = val(f, s - 1) & 1;
        else if (f > 0) prev = val(f - 1, N - 1) & 1;
        else            prev = 0;
        v = (prev << 7) | (val(f, s) >> 1);
        exp_d[en] = sx(v, 8); exp_s[en] = s; en++;
      end
    for (int f = 0; f < 2; f++) send_frame(f, L);
    finish_run("R9 shifted", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule